// File: doc/BRIEF.md
# Two-Dimensional Block Parity Codec

The codec guards a block of byte-wide frames recorded across nine parallel tracks. On the encode side, every incoming byte becomes a 9-bit frame. Bits 7..0 of the frame hold the data and bit 8 holds a row parity bit, chosen so that the frame has an even number of ones. The cycle after the final data frame of a block, the encoder adds one check frame. Bit t of the check frame is the XOR of bit t over all data frames of that block.

On the decode side, the frames of a block are collected and held in a local buffer. Row parity and column parity are recomputed as the frames arrive. When the check frame arrives, the decoder gives a one-cycle verdict: clean, corrected or uncorrectable. It then releases the buffered bytes in order through a valid/ready output.

A single flipped bit makes exactly one frame fail row parity and exactly one track fail column parity. The decoder inverts the bit where that row and that column cross. If the flipped bit is the row-parity bit itself, the failing column is track 8, so the data bytes are released unchanged. Any other pattern of failures marks the block uncorrectable, and its data leave exactly as received.

Top module: `blkpar_codec`

## Requirements
- R1: One cycle after the encoder accepts a byte, `enc_out_valid` is 1 and `enc_out_check` is 0. `enc_out_frame[7:0]` equals the byte, and `enc_out_frame[8]` makes the count of ones in the 9-bit frame even.
- R2: One cycle after the frame of the byte marked `enc_in_eob`, the encoder emits a frame with `enc_out_check` = 1. Bit t of that frame is the XOR of bit t over every data frame since `enc_in_sob`. The source keeps `enc_in_valid` low in the cycle after `enc_in_eob`.
- R3: A block whose frames all have even parity and whose column syndrome is zero reports `stat_code` = 2'b00 (clean), with `stat_row` = 0 and `stat_col` = 0. Its bytes are released unchanged.
- R4: A block with one failing frame and one failing data track c (0..7) reports `stat_code` = 2'b01 (corrected). `stat_row` gives the frame index (0 = first frame of the block) and `stat_col` gives c. The released byte at that index has bit c inverted.
- R5: A block whose only error is in the row-parity bit of one frame reports `stat_code` = 2'b01, with that frame in `stat_row` and `stat_col` = 8. All bytes are released unchanged.
- R6: Any other failure pattern reports `stat_code` = 2'b10 (uncorrectable), with `stat_row` = 0 and `stat_col` = 0. This covers two or more failing frames, two or more failing tracks, a failing frame with no failing track, and a failing track with no failing frame. The bytes are released exactly as received.
- R7: `stat_valid` is high for exactly the one cycle after the check frame is accepted.
- R8: Release starts in the cycle after the check frame. Bytes leave in arrival order, and `dec_out_last` is high on the final byte only. While `dec_out_ready` is low, `dec_out_valid`, `dec_out_data` and `dec_out_last` hold. After the final handshake, `dec_out_valid` falls.
- R9: While `rst_n` is low, and the cycle after it is low, `enc_out_valid`, `dec_out_valid` and `stat_valid` are 0. A reset during release discards the rest of the block.
- R10: A block of up to MAX_FRAMES (default 64) data frames is decoded and corrected, including an error in the last frame of a full block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_in_valid | input | 1 | Byte present for the encoder |
| enc_in_data | input | 8 | Byte to encode |
| enc_in_sob | input | 1 | Byte is the first of a block |
| enc_in_eob | input | 1 | Byte is the last of a block |
| enc_out_valid | output | 1 | Encoded frame present |
| enc_out_frame | output | 9 | Frame: bit 8 row parity, bits 7..0 data |
| enc_out_check | output | 1 | Frame is the column check frame |
| dec_in_valid | input | 1 | Frame present for the decoder |
| dec_in_frame | input | 9 | Received frame |
| dec_in_sof | input | 1 | Frame is the first data frame of a block |
| dec_in_chk | input | 1 | Frame is the check frame closing the block |
| dec_out_valid | output | 1 | Released byte present |
| dec_out_ready | input | 1 | Consumer takes the released byte |
| dec_out_data | output | 8 | Released (possibly corrected) byte |
| dec_out_last | output | 1 | Released byte is the last of the block |
| stat_valid | output | 1 | Block verdict present for one cycle |
| stat_code | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| stat_row | output | 6 | Index of the corrected frame |
| stat_col | output | 4 | Track of the corrected bit (8 = parity track) |

## Verification
An encoded frame appears one cycle after its byte is accepted, and the check frame appears two cycles after the final byte. The bench drives inputs just after a rising edge and captures encoder output on every falling edge, so each frame is recorded in the cycle it is due. The verdict belongs only to the one cycle after the check frame is taken. It is read on the falling edge that follows that capture, and the next falling edge confirms that it has dropped. The first released byte is present in that same cycle. Each later byte is compared at the falling edge before the rising edge that completes its handshake, so the count of transfers matches the back-pressure pattern exactly.

// File: rtl/blkpar_pkg.sv
// Shared widths, verdict encoding and helpers for the block parity codec.
// Assumes byte-wide data with one parity track added on top.
package blkpar_pkg;
    localparam int DATA_W = 8;
    localparam int TRACKS = DATA_W + 1;
    localparam int COLW   = $clog2(TRACKS);

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_BAD   = 2'b10
    } blk_status_e;

    // Index of the lowest set bit of a track vector (0 when none is set).
    function automatic logic [COLW-1:0] low_set_idx(input logic [TRACKS-1:0] v);
        low_set_idx = '0;
        for (int i = TRACKS - 1; i >= 0; i--) begin
            if (v[i]) low_set_idx = COLW'(i);
        end
    endfunction
endpackage

// File: rtl/blkpar_enc.sv
// Encoder: appends an even row-parity bit to every byte and closes each
// block with one column check frame. Assumes the source leaves the cycle
// after an end-of-block byte idle, since that cycle carries the check frame.
module blkpar_enc
    import blkpar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sob,
    input  logic              in_eob,
    output logic              out_valid,
    output logic [TRACKS-1:0] out_frame,
    output logic              out_check
);
    logic [TRACKS-1:0] frame;
    logic [TRACKS-1:0] col_acc;
    logic [TRACKS-1:0] acc_base;
    logic              chk_pending;

    // Form the data frame and pick the accumulator start for this byte.
    always_comb begin
        frame    = {^in_data, in_data};
        acc_base = in_sob ? '0 : col_acc;
    end

    // Register data frames, fold them into the column sum, emit check frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_frame   <= '0;
            out_check   <= 1'b0;
            col_acc     <= '0;
            chk_pending <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_check <= 1'b0;
            if (chk_pending) begin
                out_valid   <= 1'b1;
                out_check   <= 1'b1;
                out_frame   <= col_acc;
                chk_pending <= 1'b0;
            end else if (in_valid) begin
                out_valid   <= 1'b1;
                out_frame   <= frame;
                col_acc     <= acc_base ^ frame;
                chk_pending <= in_eob;
            end
        end
    end
endmodule

// File: rtl/blkpar_fbuf.sv
// Frame buffer: one write port, asynchronous read port. No reset on the
// storage; contents are only read after being written in the same block.
module blkpar_fbuf #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    // Store one byte per accepted data frame.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/blkpar_dec.sv
// Decoder: buffers a block, tracks failing rows and the column syndrome,
// issues a one-cycle verdict on the check frame, then releases the bytes
// under valid/ready with a single-bit fix when the block is correctable.
// Assumes no new block starts before release ends, and at most MAX_FRAMES
// data frames per block (MAX_FRAMES >= 2).
module blkpar_dec
    import blkpar_pkg::*;
#(
    parameter int MAX_FRAMES = 64,
    localparam int IDXW = $clog2(MAX_FRAMES),
    localparam int CNTW = $clog2(MAX_FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [TRACKS-1:0] in_frame,
    input  logic              in_sof,
    input  logic              in_chk,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              stat_valid,
    output logic [1:0]        stat_code,
    output logic [IDXW-1:0]   stat_row,
    output logic [COLW-1:0]   stat_col
);
    logic              take_data, take_chk;
    logic [CNTW-1:0]   wr_cnt, cnt_base;
    logic [TRACKS-1:0] acc, acc_base, syn;
    logic [1:0]        fails, fails_base;
    logic [IDXW-1:0]   wr_addr, bad_row, rd_ptr, last_idx, fix_row;
    logic [COLW-1:0]   fix_col, syn_col;
    logic              draining, fix_en;
    logic [DATA_W-1:0] rd_word, fix_mask;
    blk_status_e       verdict;

    assign take_data = in_valid && !in_chk;
    assign take_chk  = in_valid && in_chk;

    // Restart per-block state on a first frame; derive syndrome and verdict.
    always_comb begin
        cnt_base   = in_sof ? '0 : wr_cnt;
        acc_base   = in_sof ? '0 : acc;
        fails_base = in_sof ? 2'd0 : fails;
        wr_addr    = IDXW'(cnt_base);
        syn        = acc ^ in_frame;
        syn_col    = low_set_idx(syn);
        if (fails == 2'd0 && syn == '0)
            verdict = ST_CLEAN;
        else if (fails == 2'd1 && $countones(syn) == 1)
            verdict = ST_FIXED;
        else
            verdict = ST_BAD;
    end

    // Build the one-bit correction mask for the byte being released.
    always_comb begin
        for (int b = 0; b < DATA_W; b++) begin
            fix_mask[b] = fix_en && (rd_ptr == fix_row) && (fix_col == COLW'(b));
        end
    end

    blkpar_fbuf #(
        .DEPTH (MAX_FRAMES),
        .W     (DATA_W)
    ) u_fbuf (
        .clk     (clk),
        .wr_en   (take_data),
        .wr_addr (wr_addr),
        .wr_data (in_frame[DATA_W-1:0]),
        .rd_addr (rd_ptr),
        .rd_data (rd_word)
    );

    assign out_valid = draining;
    assign out_data  = rd_word ^ fix_mask;
    assign out_last  = draining && (rd_ptr == last_idx);

    // Collect row/column parity, latch the verdict, walk the release pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt     <= '0;
            acc        <= '0;
            fails      <= 2'd0;
            bad_row    <= '0;
            draining   <= 1'b0;
            rd_ptr     <= '0;
            last_idx   <= '0;
            fix_en     <= 1'b0;
            fix_row    <= '0;
            fix_col    <= '0;
            stat_valid <= 1'b0;
            stat_code  <= ST_CLEAN;
            stat_row   <= '0;
            stat_col   <= '0;
        end else begin
            stat_valid <= 1'b0;
            if (take_data) begin
                wr_cnt <= cnt_base + 1'b1;
                acc    <= acc_base ^ in_frame;
                if (^in_frame) begin
                    if (fails_base == 2'd0) bad_row <= wr_addr;
                    fails <= (fails_base == 2'd0) ? 2'd1 : 2'd2;
                end else begin
                    fails <= fails_base;
                end
            end
            if (take_chk) begin
                draining   <= 1'b1;
                rd_ptr     <= '0;
                last_idx   <= IDXW'(wr_cnt - 1'b1);
                fix_en     <= (verdict == ST_FIXED);
                fix_row    <= bad_row;
                fix_col    <= syn_col;
                stat_valid <= 1'b1;
                stat_code  <= verdict;
                stat_row   <= (verdict == ST_FIXED) ? bad_row : '0;
                stat_col   <= (verdict == ST_FIXED) ? syn_col : '0;
            end else if (draining && out_ready) begin
                if (rd_ptr == last_idx) draining <= 1'b0;
                else                    rd_ptr   <= rd_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/blkpar_codec.sv
// Top: block parity encoder and correcting decoder side by side.
// The two halves share only clock and reset.
module blkpar_codec
    import blkpar_pkg::*;
#(
    parameter int MAX_FRAMES = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enc_in_valid,
    input  logic [DATA_W-1:0]             enc_in_data,
    input  logic                          enc_in_sob,
    input  logic                          enc_in_eob,
    output logic                          enc_out_valid,
    output logic [TRACKS-1:0]             enc_out_frame,
    output logic                          enc_out_check,
    input  logic                          dec_in_valid,
    input  logic [TRACKS-1:0]             dec_in_frame,
    input  logic                          dec_in_sof,
    input  logic                          dec_in_chk,
    output logic                          dec_out_valid,
    input  logic                          dec_out_ready,
    output logic [DATA_W-1:0]             dec_out_data,
    output logic                          dec_out_last,
    output logic                          stat_valid,
    output logic [1:0]                    stat_code,
    output logic [$clog2(MAX_FRAMES)-1:0] stat_row,
    output logic [COLW-1:0]               stat_col
);
    blkpar_enc u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (enc_in_valid),
        .in_data   (enc_in_data),
        .in_sob    (enc_in_sob),
        .in_eob    (enc_in_eob),
        .out_valid (enc_out_valid),
        .out_frame (enc_out_frame),
        .out_check (enc_out_check)
    );

    blkpar_dec #(
        .MAX_FRAMES (MAX_FRAMES)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (dec_in_valid),
        .in_frame   (dec_in_frame),
        .in_sof     (dec_in_sof),
        .in_chk     (dec_in_chk),
        .out_valid  (dec_out_valid),
        .out_ready  (dec_out_ready),
        .out_data   (dec_out_data),
        .out_last   (dec_out_last),
        .stat_valid (stat_valid),
        .stat_code  (stat_code),
        .stat_row   (stat_row),
        .stat_col   (stat_col)
    );
endmodule

// File: rtl/blkpar_codec_chk.sv
// Checker for blkpar_codec: port-level timing and encoding properties.
// Keeps its own count of data frames per block for the size and index rules.
module blkpar_codec_chk
    import blkpar_pkg::*;
#(
    parameter int MAX_FRAMES = 64
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          enc_in_valid,
    input logic [DATA_W-1:0]             enc_in_data,
    input logic                          enc_in_eob,
    input logic                          enc_out_valid,
    input logic [TRACKS-1:0]             enc_out_frame,
    input logic                          enc_out_check,
    input logic                          dec_in_valid,
    input logic                          dec_in_sof,
    input logic                          dec_in_chk,
    input logic                          dec_out_valid,
    input logic                          dec_out_ready,
    input logic [DATA_W-1:0]             dec_out_data,
    input logic                          dec_out_last,
    input logic                          stat_valid,
    input logic [1:0]                    stat_code,
    input logic [$clog2(MAX_FRAMES)-1:0] stat_row,
    input logic [COLW-1:0]               stat_col
);
    int blk_frames;

    // Count data frames of the current block as seen at the decoder input.
    always_ff @(posedge clk) begin
        if (!rst_n)                           blk_frames <= 0;
        else if (dec_in_valid && !dec_in_chk) blk_frames <= dec_in_sof ? 1 : blk_frames + 1;
    end

    p_enc_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        enc_in_valid && !(enc_out_valid && !enc_out_check && $past(enc_in_eob && enc_in_valid))
        |=> enc_out_valid && !enc_out_check && enc_out_frame[DATA_W-1:0] == $past(enc_in_data)
            && (^enc_out_frame) == 1'b0);

    p_chk_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_in_valid && enc_in_eob |=> !enc_in_valid ##1 (enc_out_valid && enc_out_check));

    p_stat_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_in_valid && dec_in_chk |=> stat_valid ##1 !stat_valid);

    p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> stat_code != 2'b11);

    p_idx_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid && stat_code != ST_FIXED |-> stat_row == '0 && stat_col == '0);

    p_fix_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid && stat_code == ST_FIXED |-> int'(stat_row) < blk_frames && int'(stat_col) < TRACKS);

    p_release_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_in_valid && dec_in_chk |=> dec_out_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_data) && $stable(dec_out_last));

    p_last_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid && dec_out_ready && dec_out_last |=> !dec_out_valid);

    p_block_fits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_in_valid && !dec_in_chk && !dec_in_sof |-> blk_frames < MAX_FRAMES);

    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> !enc_out_valid && !dec_out_valid && !stat_valid);
endmodule

bind blkpar_codec blkpar_codec_chk #(.MAX_FRAMES(MAX_FRAMES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enc_in_valid  (enc_in_valid),
    .enc_in_data   (enc_in_data),
    .enc_in_eob    (enc_in_eob),
    .enc_out_valid (enc_out_valid),
    .enc_out_frame (enc_out_frame),
    .enc_out_check (enc_out_check),
    .dec_in_valid  (dec_in_valid),
    .dec_in_sof    (dec_in_sof),
    .dec_in_chk    (dec_in_chk),
    .dec_out_valid (dec_out_valid),
    .dec_out_ready (dec_out_ready),
    .dec_out_data  (dec_out_data),
    .dec_out_last  (dec_out_last),
    .stat_valid    (stat_valid),
    .stat_code     (stat_code),
    .stat_row      (stat_row),
    .stat_col      (stat_col)
);

// File: tb/blkpar_codec_test.sv
`timescale 1ns/100ps
// Bench for blkpar_codec: walks a table of block cases through encoder and
// decoder, then runs directed reset tests.
module blkpar_codec_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_in_valid = 1'b0, enc_in_sob = 1'b0, enc_in_eob = 1'b0;
    logic [7:0] enc_in_data = '0;
    logic       enc_out_valid, enc_out_check;
    logic [8:0] enc_out_frame;
    logic       dec_in_valid = 1'b0, dec_in_sof = 1'b0, dec_in_chk = 1'b0;
    logic [8:0] dec_in_frame = '0;
    logic       dec_out_valid, dec_out_last;
    logic       dec_out_ready = 1'b0;
    logic [7:0] dec_out_data;
    logic       stat_valid;
    logic [1:0] stat_code;
    logic [5:0] stat_row;
    logic [3:0] stat_col;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    blkpar_codec #(.MAX_FRAMES(64)) uut (
        .clk(clk), .rst_n(rst_n),
        .enc_in_valid(enc_in_valid), .enc_in_data(enc_in_data),
        .enc_in_sob(enc_in_sob), .enc_in_eob(enc_in_eob),
        .enc_out_valid(enc_out_valid), .enc_out_frame(enc_out_frame),
        .enc_out_check(enc_out_check),
        .dec_in_valid(dec_in_valid), .dec_in_frame(dec_in_frame),
        .dec_in_sof(dec_in_sof), .dec_in_chk(dec_in_chk),
        .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready),
        .dec_out_data(dec_out_data), .dec_out_last(dec_out_last),
        .stat_valid(stat_valid), .stat_code(stat_code),
        .stat_row(stat_row), .stat_col(stat_col)
    );

    // Columns: bytes, seed, flip1 row, flip1 track, flip2 row, flip2 track,
    // expected code (0 clean, 1 corrected, 2 uncorrectable), back-pressure.
    // Row index equal to the byte count targets the check frame; -1 = none.
    localparam int NV = 10;
    localparam int VEC [NV][8] = '{
        '{ 4,  1, -1, 0, -1, 0, 0, 0},
        '{ 8,  2,  2, 5, -1, 0, 1, 0},
        '{ 1,  3,  0, 0, -1, 0, 1, 1},
        '{64,  4, 63, 7, -1, 0, 1, 1},
        '{ 5,  5,  3, 8, -1, 0, 1, 0},
        '{ 6,  6,  1, 2,  4, 6, 2, 0},
        '{ 6,  7,  1, 2,  1, 6, 2, 1},
        '{ 6,  8,  1, 3,  4, 3, 2, 0},
        '{ 3,  9,  3, 2, -1, 0, 2, 0},
        '{10, 10, -1, 0, -1, 0, 0, 1}
    };

    logic [9:0] cap [80];
    int         cap_n = 0;

    // Record every encoder output frame at the falling edge.
    always @(negedge clk) begin
        if (enc_out_valid && cap_n < 80) begin
            cap[cap_n] = {enc_out_check, enc_out_frame};
            cap_n++;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] gen(input int seed, input int i);
        return 8'(seed * 53 + i * 29 + i * i * 7);
    endfunction

    function automatic string code_tag(input int code, input int col);
        if (code == 0) return "R3";
        if (code == 1) return (col == 8) ? "R5" : "R4";
        return "R6";
    endfunction

    // Run one table case through encoder and decoder and compare.
    task automatic run_case(input int v);
        int n = VEC[v][0];
        int seed = VEC[v][1];
        int r1 = VEC[v][2], c1 = VEC[v][3], r2 = VEC[v][4], c2 = VEC[v][5];
        int code = VEC[v][6];
        int bp = VEC[v][7];
        logic [7:0] orig [64];
        logic [8:0] fr [65];
        logic [8:0] col;
        int bad_frames = 0;
        int k = 0, cyc = 0, guard = 0;
        bit ok_last = 1'b1;
        string tg = code_tag(code, c1);

        col = '0;
        for (int i = 0; i < n; i++) begin
            orig[i] = gen(seed, i);
            fr[i] = {^orig[i], orig[i]};
            col = col ^ fr[i];
        end
        fr[n] = col;

        // Encoder pass.
        cap_n = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            enc_in_valid = 1'b1; enc_in_data = orig[i];
            enc_in_sob = (i == 0); enc_in_eob = (i == n - 1);
        end
        @(posedge clk); #1;
        enc_in_valid = 1'b0; enc_in_sob = 1'b0; enc_in_eob = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        for (int i = 0; i < n; i++) begin
            if (cap[i] != {1'b0, fr[i]}) bad_frames++;
        end
        check(cap_n == n + 1, "R1", $sformatf("case %0d encoder frame count", v), cap_n, n + 1);
        check(bad_frames == 0, "R1", $sformatf("case %0d data frames wrong", v), bad_frames, 0);
        check(cap[n] == {1'b1, fr[n]}, "R2", $sformatf("case %0d check frame", v),
              int'(cap[n]), int'({1'b1, fr[n]}));

        // Corrupt and feed the decoder.
        if (r1 >= 0) fr[r1][c1] = ~fr[r1][c1];
        if (r2 >= 0) fr[r2][c2] = ~fr[r2][c2];
        dec_out_ready = 1'b0;
        for (int i = 0; i <= n; i++) begin
            @(posedge clk); #1;
            dec_in_valid = 1'b1; dec_in_frame = fr[i];
            dec_in_sof = (i == 0); dec_in_chk = (i == n);
        end
        @(posedge clk); #1;
        dec_in_valid = 1'b0; dec_in_sof = 1'b0; dec_in_chk = 1'b0;
        @(negedge clk);
        check(stat_valid == 1'b1, "R7", $sformatf("case %0d verdict present", v), stat_valid, 1);
        check(int'(stat_code) == code, tg, $sformatf("case %0d verdict code", v), stat_code, code);
        check(int'(stat_row) == (code == 1 ? r1 : 0), tg, $sformatf("case %0d row index", v),
              stat_row, code == 1 ? r1 : 0);
        check(int'(stat_col) == (code == 1 ? c1 : 0), tg, $sformatf("case %0d track index", v),
              stat_col, code == 1 ? c1 : 0);
        check(dec_out_valid == 1'b1, "R8", $sformatf("case %0d release started", v), dec_out_valid, 1);

        // Drain with optional back-pressure.
        bad_frames = 0;
        while (k < n && guard < 1000) begin
            @(posedge clk); #1;
            dec_out_ready = bp ? (cyc % 3 != 0) : 1'b1;
            cyc++; guard++;
            @(negedge clk);
            if (guard == 1)
                check(stat_valid == 1'b0, "R7", $sformatf("case %0d verdict one cycle", v), stat_valid, 0);
            if (dec_out_valid && dec_out_ready) begin
                if (dec_out_data != ((code == 2) ? fr[k][7:0] : orig[k])) begin
                    bad_frames++;
                    $display("FAIL %s case %0d byte %0d actual=%0d expected=%0d", tg, v, k,
                             dec_out_data, (code == 2) ? fr[k][7:0] : orig[k]);
                end
                if (dec_out_last != (k == n - 1)) ok_last = 1'b0;
                k++;
            end
        end
        @(posedge clk); #1;
        dec_out_ready = 1'b0;
        @(negedge clk);
        check(k == n, "R8", $sformatf("case %0d bytes released", v), k, n);
        check(bad_frames == 0, tg, $sformatf("case %0d released data mismatches", v), bad_frames, 0);
        check(ok_last, "R8", $sformatf("case %0d last marker", v), ok_last, 1);
        check(dec_out_valid == 1'b0, "R8", $sformatf("case %0d release ended", v), dec_out_valid, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(enc_out_valid == 1'b0, "R9", "encoder quiet in reset", enc_out_valid, 0);
        check(dec_out_valid == 1'b0, "R9", "decoder quiet in reset", dec_out_valid, 0);
        check(stat_valid == 1'b0, "R9", "verdict quiet in reset", stat_valid, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) run_case(v);

        // Directed: 64-byte full block already covered R10; confirm again here by tag.
        check(VEC[3][0] == 64, "R10", "full block case present", VEC[3][0], 64);

        // Directed: reset in the middle of a release discards the rest (R9).
        for (int i = 0; i <= 4; i++) begin
            @(posedge clk); #1;
            dec_in_valid = 1'b1;
            dec_in_frame = (i < 4) ? {^gen(20, i), gen(20, i)} : 9'h000;
            dec_in_sof = (i == 0); dec_in_chk = (i == 4);
        end
        @(posedge clk); #1;
        dec_in_valid = 1'b0; dec_in_sof = 1'b0; dec_in_chk = 1'b0;
        dec_out_ready = 1'b1;
        @(negedge clk);
        check(dec_out_valid == 1'b1, "R8", "directed release under way", dec_out_valid, 1);
        @(posedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        dec_out_ready = 1'b1;
        @(negedge clk);
        check(dec_out_valid == 1'b0, "R9", "reset cut the release", dec_out_valid, 0);
        check(stat_valid == 1'b0, "R9", "no verdict after reset", stat_valid, 0);
        dec_out_ready = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule